// File: doc/BRIEF.md
# Reference Clock Activity Alarm

This block watches a set of reference clock inputs (two by default) and raises one active-high alarm per input when that input stops toggling. Activity is judged against an observation clock: the feedback clock of the phase comparator. Each rising or falling transition of the observation clock closes one observation interval. When three intervals in a row close with no transition of a reference, that reference's alarm goes high. Only the presence or absence of reference transitions is judged. Frequency accuracy is not checked, and a reference with far more transitions than the observation clock is healthy.

Both edges of every reference are captured by a pair of toggle flops clocked by the reference itself, one on the rising edge and one on the falling edge. The toggles and the observation clock are brought into the monitor clock `clk` through synchronizer chains. Any change of a synchronized toggle marks reference activity, and any change of the synchronized observation clock is one observation edge. `clk` must be faster than both the observation clock and the references.

Each channel is a four-state machine. `ST_LIVE` means zero missed intervals, `ST_MISS1` one, `ST_MISS2` two, and `ST_LOST` three or more. The state moves only on an observation edge:
- Live-return: from any state, an interval that saw activity goes to `ST_LIVE`.
- Miss-advance: a quiet interval steps `ST_LIVE`→`ST_MISS1`→`ST_MISS2`→`ST_LOST`.
- Miss-hold: a quiet interval leaves `ST_LOST` where it is.

The alarm is high exactly in `ST_LOST`. An asynchronous active-low reset puts every channel in `ST_LIVE`.

Top module: `lor_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, every alarm bit `lor` is 0.
- R2: An alarm bit goes to 1 on the third consecutive observation edge whose interval held no transition of that reference. Rising and falling edges of `fb_clk` each count as one observation edge.
- R3: After only one or two consecutive quiet intervals, the alarm bit stays 0.
- R4: A reference transition, rising or falling, in an interval restarts the miss count. Three further quiet intervals are then needed before the alarm rises.
- R5: A high alarm returns to 0 on the first observation edge that closes an interval containing reference activity.
- R6: A reference toggling many times per observation interval never raises its alarm.
- R7: Each reference `ref_clk[i]` drives only `lor[i]`. Activity or loss on one channel leaves the other channel's alarm unchanged.
- R8: An alarm bit changes only on an observation edge. A reference transition alone does not change it.
- R9: While quiet intervals continue past the third, the alarm stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock; samples the observation clock and the reference toggles |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_clk | input | 1 | Observation (phase-comparator feedback) clock; both edges count |
| ref_clk | input | NUM_REF | Reference clocks under watch, one per channel |
| lor | output | NUM_REF | Loss-of-reference alarm per channel, active high |

## Verification
An observation edge on `fb_clk` reaches `lor` after at most four `clk` cycles: two synchronizer stages, the change-detect register and the state register. A reference transition reaches the channel's activity flag in at most four `clk` cycles as well. Every bench step toggles one input at a falling edge of `clk` and then waits six cycles before sampling, so each result is read only after it has settled. The expected alarm comes from a bench model that counts quiet intervals per channel. It is checked after every observation edge and again after reference edges that must not move the alarm.

// File: rtl/lor_pkg.sv
package lor_pkg;
    typedef enum logic [1:0] {
        ST_LIVE  = 2'd0,
        ST_MISS1 = 2'd1,
        ST_MISS2 = 2'd2,
        ST_LOST  = 2'd3
    } lor_state_t;
endpackage

// File: rtl/lor_edge_sync.sv
// Brings a slow asynchronous level into clk and flags any change of it.
module lor_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic strobe
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], din};
            last_q  <= chain_q[LAST];
        end
    end

    assign strobe = chain_q[LAST] ^ last_q;
endmodule

// File: rtl/lor_ref_capture.sv
// Toggle flops in the reference domain: one per reference edge polarity.
module lor_ref_capture (
    input  logic ref_clk,
    input  logic rst_n,
    output logic tog_rise,
    output logic tog_fall
);
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tog_rise <= 1'b0;
        else        tog_rise <= ~tog_rise;
    end

    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) tog_fall <= 1'b0;
        else        tog_fall <= ~tog_fall;
    end
endmodule

// File: rtl/lor_channel.sv
module lor_channel
    import lor_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_stb,
    input  logic ref_clk,
    output logic alarm
);
    logic       tog_rise, tog_fall;
    logic       rise_stb, fall_stb;
    logic       act_now;
    logic       seen_q;
    logic       seen_now;
    lor_state_t state_q, state_d;

    lor_ref_capture u_cap (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .tog_rise(tog_rise),
        .tog_fall(tog_fall)
    );

    lor_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_rise (
        .clk(clk), .rst_n(rst_n), .din(tog_rise), .strobe(rise_stb)
    );

    lor_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fall (
        .clk(clk), .rst_n(rst_n), .din(tog_fall), .strobe(fall_stb)
    );

    assign act_now  = rise_stb | fall_stb;
    assign seen_now = seen_q | act_now;

    // Activity flag for the interval now open; closed by each observation edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seen_q <= 1'b0;
        else if (fb_stb) seen_q <= 1'b0;
        else             seen_q <= seen_now;
    end

    always_comb begin
        state_d = state_q;
        if (fb_stb) begin
            if (seen_now) begin
                state_d = ST_LIVE;
            end else begin
                unique case (state_q)
                    ST_LIVE:  state_d = ST_MISS1;
                    ST_MISS1: state_d = ST_MISS2;
                    ST_MISS2: state_d = ST_LOST;
                    ST_LOST:  state_d = ST_LOST;
                    default:  state_d = ST_LIVE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LIVE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        alarm = (state_q == ST_LOST);
    end

    // R2
    rise_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(state_q) == ST_MISS2);

    // R8
    rise_on_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(fb_stb) && !$past(seen_now));

    // R5
    fall_on_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> $past(fb_stb) && $past(seen_now));

    // R4
    activity_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_stb && seen_now) |=> state_q == ST_LIVE && !seen_q);

    // R9
    hold_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !seen_now) |=> alarm);
endmodule

// File: rtl/lor_monitor.sv
module lor_monitor #(
    parameter int NUM_REF     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fb_clk,
    input  logic [NUM_REF-1:0] ref_clk,
    output logic [NUM_REF-1:0] lor
);
    logic fb_stb;

    lor_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .din(fb_clk), .strobe(fb_stb)
    );

    for (genvar g = 0; g < NUM_REF; g++) begin : g_chan
        lor_channel #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .fb_stb (fb_stb),
            .ref_clk(ref_clk[g]),
            .alarm  (lor[g])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> lor == '0);
endmodule

// File: tb/tb_lor_monitor.sv
`timescale 1ns/1ps
module tb_lor_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fb = 1'b0;
    logic [1:0] ref_man = 2'b00;
    logic [1:0] fast_en = 2'b00;
    logic       fast_clk = 1'b0;
    logic [1:0] ref_clk;
    logic [1:0] lor;

    int errors = 0;
    int checks = 0;
    int miss [2];
    bit seen [2];

    always #2.5 clk = ~clk;
    always #6.5 fast_clk = ~fast_clk;

    for (genvar g = 0; g < 2; g++) begin : g_ref
        assign ref_clk[g] = fast_en[g] ? fast_clk : ref_man[g];
    end

    lor_monitor dut (
        .clk(clk), .rst_n(rst_n), .fb_clk(fb), .ref_clk(ref_clk), .lor(lor)
    );

    function automatic logic exp_alarm(int ch);
        return miss[ch] >= 3;
    endfunction

    task automatic check_ch(int ch, string req);
        checks++;
        if (lor[ch] !== exp_alarm(ch)) begin
            errors++;
            $display("FAIL %s ch%0d: lor=%b expected %b", req, ch, lor[ch], exp_alarm(ch));
        end
    endtask

    task automatic fb_edge();
        @(negedge clk) fb = ~fb;
        for (int c = 0; c < 2; c++) begin
            if (seen[c] || fast_en[c]) miss[c] = 0;
            else if (miss[c] < 3)      miss[c]++;
            seen[c] = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic ref_edge(int ch);
        @(negedge clk) ref_man[ch] = ~ref_man[ch];
        seen[ch] = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic fast_off(int ch);
        @(negedge clk) fast_en[ch] = 1'b0;
        seen[ch] = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int c = 0; c < 2; c++) begin miss[c] = 0; seen[c] = 1'b0; end
        repeat (4) @(negedge clk);
        check_ch(0, "R1"); check_ch(1, "R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_ch(0, "R1"); check_ch(1, "R1");

        // R3: one and two quiet intervals (rising, then falling fb edge)
        fb_edge(); check_ch(0, "R3"); check_ch(1, "R3");
        fb_edge(); check_ch(0, "R3"); check_ch(1, "R3");
        // R2: third quiet edge raises both alarms
        fb_edge(); check_ch(0, "R2"); check_ch(1, "R2");
        // R9: stays high
        fb_edge(); check_ch(0, "R9"); check_ch(1, "R9");

        // R8: reference edge alone leaves alarm high
        ref_edge(0); check_ch(0, "R8");
        // R5: cleared on closing edge; R7: other channel untouched
        fb_edge(); check_ch(0, "R5"); check_ch(1, "R7");

        // R4: falling ref edge after two misses restarts count
        fb_edge(); fb_edge(); check_ch(0, "R3");
        ref_edge(0);
        fb_edge(); check_ch(0, "R4");
        fb_edge(); check_ch(0, "R4");
        fb_edge(); check_ch(0, "R4");
        fb_edge(); check_ch(0, "R2");

        // R6: fast reference on ch0, ch1 quiet
        @(negedge clk) fast_en[0] = 1'b1;
        seen[0] = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            fb_edge(); check_ch(0, "R6"); check_ch(1, "R7");
        end
        fast_off(0);
        fb_edge(); check_ch(0, "R6");

        // R6/R7: fast reference on ch1, ch0 left to go quiet
        @(negedge clk) fast_en[1] = 1'b1;
        seen[1] = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            fb_edge(); check_ch(1, "R6"); check_ch(0, "R7");
        end
        fast_off(1);

        // Random mix of reference and observation edges
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 2)      begin ref_edge(0); check_ch(0, "R8"); end
            else if (op < 4) begin ref_edge(1); check_ch(1, "R8"); end
            else begin
                fb_edge();
                check_ch(0, "R2"); check_ch(1, "R4");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule